// File: doc/BRIEF.md
# FIFO Pointer Realignment Controller

This block sits between a small register bus and a set of elastic FIFOs (two by default, port A at index 0 and port B at index 1). Software asks for a write-pointer realignment of one FIFO by setting a request bit and a target phase offset in that port's control/status register. The controller takes the request and sends the FIFO a one-cycle realignment command that carries the captured offset. It holds an acknowledge bit high while the FIFO works. When the FIFO reports that its write pointer has moved, the acknowledge bit drops and a shared sticky aligned event is set. Software can tell which port finished from the acknowledge bit that went low.

A second trigger source exists: when frame-triggered mode is on, a rising edge on a port's frame input queues a realignment that uses the offset held in that port's register. In single-clock mode only the port A frame input is used, and it drives every port. One interrupt output combines the aligned event with the FIFO warning flags that software has enabled.

Each port holds at most one request in addition to the realignment in progress. A request that arrives during a realignment waits and is issued once the current one completes. Every accepted request gives exactly one command.

Top module: `fifo_realign_ctrl`

## Requirements
- R1: After reset, every register reads 0 except the warning bits (which follow `fifo_warn`), `realign_cmd` is 0, `aligned_event` is 0, and `irq` is 0 while the warnings are low.
- R2: Port p's register lives at address p. It holds the offset in bits [2:0], the request in bit 3, the acknowledge in bit 4 and `fifo_warn[p]` in bit 7. Bits 6:5 read 0. Writes to bits 4 to 7 have no effect.
- R3: A write to a port register with bit 3 = 1, while that port's stored request bit is 0, is a request. The cycle after the write edge, `realign_cmd[p]` is high for exactly one cycle, with the offset from that write on `realign_offset`.
- R4: The acknowledge bit reads 1 from the edge that issues the command up to the edge at which `fifo_realigned[p]` is high, and reads 0 afterwards.
- R5: `realign_offset` holds the offset captured at request time. Later writes that change the register's offset field do not alter it while the acknowledge bit is 1.
- R6: At the edge that clears the acknowledge bit, `aligned_event` is set. A `fifo_realigned[p]` pulse on a port whose acknowledge bit is 0 is ignored.
- R7: Writing 1 to bit 0 of address 2 clears `aligned_event`, and writing 0 leaves it unchanged. A completion in the same cycle as the clear wins, so the flag stays 1.
- R8: A request made while a realignment is pending is held and issued the cycle after the completion edge. Writing bit 3 = 1 while the stored request bit is already 1 is not a new request. Each request produces exactly one command.
- R9: The mode register at address 3 has bits [1:0] = warning interrupt enable per port, bit 2 = frame-triggered mode, bit 3 = single-clock mode, and the other bits read 0. `irq` = `aligned_event` OR any warning whose enable bit is set.
- R10: With frame-triggered mode on, a 0-to-1 change of a port's frame source queues a request with the offset currently in that port's register. Holding the frame high gives no further requests, and with the mode off frame edges are ignored.
- R11: In single-clock mode, `frame_in[0]` triggers every port and `frame_in[1]` is ignored.
- R12: Port p's command offset appears on `realign_offset[3p+2:3p]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| frame_in | input | 2 | Per-port frame inputs |
| fifo_warn | input | 2 | Per-port FIFO near-empty/near-full warnings |
| fifo_realigned | input | 2 | Per-port pulse: write pointer realigned |
| realign_cmd | output | 2 | Per-port one-cycle realignment command |
| realign_offset | output | 6 | Per-port captured phase offset, 3 bits each |
| aligned_event | output | 1 | Sticky aligned event flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that a command lasts exactly one cycle and that the acknowledge bit rises only together with a command. They also check that the issued offset stays fixed while the acknowledge bit is high, that the event flag rises only after a completion and stays set unless software clears it, and that the interrupt is raised whenever the event is set. Only the bench scenarios can show the more complex behaviour: queuing a second request behind a pending one, ignoring repeated request writes and stray completions, completion winning over a clear in the same cycle, frame edge detection, and single-clock fan-out of the frame source.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int REG_W    = 8;
  localparam int OFF_W    = 3;
  localparam int REQ_BIT  = 3;
  localparam int ACK_BIT  = 4;
  localparam int WARN_BIT = 7;

  typedef enum logic {PH_IDLE = 1'b0, PH_WAIT = 1'b1} phase_e;

  // Build a port control/status word from its fields.
  function automatic logic [REG_W-1:0] pack_port(input logic [OFF_W-1:0] off,
                                                 input logic req,
                                                 input logic ack,
                                                 input logic warn);
    logic [REG_W-1:0] r;
    r = '0;
    r[OFF_W-1:0] = off;
    r[REQ_BIT]   = req;
    r[ACK_BIT]   = ack;
    r[WARN_BIT]  = warn;
    return r;
  endfunction

  // Interrupt combine: sticky event or any enabled warning.
  function automatic logic irq_of(input logic evt, input logic [7:0] warn,
                                  input logic [7:0] en);
    return evt | (|(warn & en));
  endfunction
endpackage

// File: rtl/fr_port_ctrl.sv
module fr_port_ctrl
  import fr_pkg::*;
#(
  parameter int OW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [OW-1:0] trig_off,
  input  logic          done,
  output logic          cmd,
  output logic [OW-1:0] cmd_off,
  output logic          busy,
  output logic          issue_evt,
  output logic          finish_evt
);
  phase_e        ph_q;
  logic          queued_q;
  logic [OW-1:0] queued_off_q;
  logic [OW-1:0] cmd_off_q;
  logic          cmd_q;
  logic          take_w;

  assign issue_evt  = (ph_q == PH_IDLE) && queued_q;
  assign finish_evt = (ph_q == PH_WAIT) && done;
  // One held slot; a slot being issued this cycle can take a new trigger.
  assign take_w     = trig && (!queued_q || issue_evt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q         <= PH_IDLE;
      queued_q     <= 1'b0;
      queued_off_q <= '0;
      cmd_off_q    <= '0;
      cmd_q        <= 1'b0;
    end else begin
      cmd_q <= issue_evt;
      if (issue_evt) begin
        ph_q      <= PH_WAIT;
        cmd_off_q <= queued_off_q;
      end else if (finish_evt) begin
        ph_q <= PH_IDLE;
      end
      if (take_w) begin
        queued_q     <= 1'b1;
        queued_off_q <= trig_off;
      end else if (issue_evt) begin
        queued_q <= 1'b0;
      end
    end
  end

  assign cmd     = cmd_q;
  assign cmd_off = cmd_off_q;
  assign busy    = (ph_q == PH_WAIT);
endmodule

// File: rtl/fr_frame_trig.sv
module fr_frame_trig #(
  parameter int NP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] frame_in,
  input  logic          frame_en,
  input  logic          single_clk,
  output logic [NP-1:0] rise
);
  logic [NP-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n) frame_q <= '0;
    else        frame_q <= frame_in;
  end

  for (genvar p = 0; p < NP; p++) begin : g_src
    logic cur_w, prev_w;
    if (p == 0) begin : g_a
      assign cur_w  = frame_in[0];
      assign prev_w = frame_q[0];
    end else begin : g_other
      assign cur_w  = single_clk ? frame_in[0] : frame_in[p];
      assign prev_w = single_clk ? frame_q[0]  : frame_q[p];
    end
    assign rise[p] = frame_en && cur_w && !prev_w;
  end
endmodule

// File: rtl/fr_event_irq.sv
module fr_event_irq
  import fr_pkg::*;
#(
  parameter int NP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] set_vec,
  input  logic          clr,
  input  logic [NP-1:0] warn,
  input  logic [NP-1:0] warn_en,
  output logic          evt,
  output logic          irq
);
  logic evt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        evt_q <= 1'b0;
    else if (|set_vec) evt_q <= 1'b1;
    else if (clr)      evt_q <= 1'b0;
  end

  assign evt = evt_q;
  assign irq = irq_of(evt_q, 8'(warn), 8'(warn_en));
endmodule

// File: rtl/fifo_realign_ctrl.sv
module fifo_realign_ctrl
  import fr_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  localparam int ADDR_W   = $clog2(NUM_PORTS + 2),
  localparam int OW       = fr_pkg::OFF_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [REG_W-1:0]       reg_wdata,
  output logic [REG_W-1:0]       reg_rdata,
  input  logic [NUM_PORTS-1:0]   frame_in,
  input  logic [NUM_PORTS-1:0]   fifo_warn,
  input  logic [NUM_PORTS-1:0]   fifo_realigned,
  output logic [NUM_PORTS-1:0]   realign_cmd,
  output logic [NUM_PORTS*OW-1:0] realign_offset,
  output logic                   aligned_event,
  output logic                   irq
);
  localparam int EVT_ADDR  = NUM_PORTS;
  localparam int MODE_ADDR = NUM_PORTS + 1;

  logic [NUM_PORTS-1:0] req_q;
  logic [OW-1:0]        off_q [NUM_PORTS];
  logic [NUM_PORTS-1:0] warn_en_q;
  logic                 frame_en_q;
  logic                 single_q;

  // Named internal events
  logic [NUM_PORTS-1:0] port_wr_w;
  logic [NUM_PORTS-1:0] sw_trig_w;
  logic [NUM_PORTS-1:0] frame_rise_w;
  logic [NUM_PORTS-1:0] issue_evt_w;
  logic [NUM_PORTS-1:0] finish_evt_w;
  logic [NUM_PORTS-1:0] busy_w;
  logic                 mode_wr_w;
  logic                 evt_clr_w;
  logic                 unused_hi_bits;

  assign mode_wr_w = reg_wr && (reg_addr == ADDR_W'(MODE_ADDR));
  assign evt_clr_w = reg_wr && (reg_addr == ADDR_W'(EVT_ADDR)) && reg_wdata[0];
  assign unused_hi_bits = ^reg_wdata[REG_W-1:NUM_PORTS+2];

  fr_frame_trig #(.NP(NUM_PORTS)) frame_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_in   (frame_in),
    .frame_en   (frame_en_q),
    .single_clk (single_q),
    .rise       (frame_rise_w)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [OW-1:0] trig_off_w;
    logic [OW-1:0] cmd_off_w;

    assign port_wr_w[p] = reg_wr && (reg_addr == ADDR_W'(p));
    assign sw_trig_w[p] = port_wr_w[p] && reg_wdata[REQ_BIT] && !req_q[p];
    assign trig_off_w   = sw_trig_w[p] ? reg_wdata[OW-1:0] : off_q[p];

    fr_port_ctrl #(.OW(OW)) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig       (sw_trig_w[p] | frame_rise_w[p]),
      .trig_off   (trig_off_w),
      .done       (fifo_realigned[p]),
      .cmd        (realign_cmd[p]),
      .cmd_off    (cmd_off_w),
      .busy       (busy_w[p]),
      .issue_evt  (issue_evt_w[p]),
      .finish_evt (finish_evt_w[p])
    );

    assign realign_offset[p*OW +: OW] = cmd_off_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q      <= '0;
      warn_en_q  <= '0;
      frame_en_q <= 1'b0;
      single_q   <= 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) off_q[p] <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (port_wr_w[p]) begin
          req_q[p] <= reg_wdata[REQ_BIT];
          off_q[p] <= reg_wdata[OW-1:0];
        end
      end
      if (mode_wr_w) begin
        warn_en_q  <= reg_wdata[NUM_PORTS-1:0];
        frame_en_q <= reg_wdata[NUM_PORTS];
        single_q   <= reg_wdata[NUM_PORTS+1];
      end
    end
  end

  fr_event_irq #(.NP(NUM_PORTS)) evt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (finish_evt_w),
    .clr     (evt_clr_w),
    .warn    (fifo_warn),
    .warn_en (warn_en_q),
    .evt     (aligned_event),
    .irq     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (reg_addr == ADDR_W'(p))
        reg_rdata = pack_port(off_q[p], req_q[p], busy_w[p], fifo_warn[p]);
    end
    if (reg_addr == ADDR_W'(EVT_ADDR)) begin
      reg_rdata[0] = aligned_event;
    end
    if (reg_addr == ADDR_W'(MODE_ADDR)) begin
      reg_rdata[NUM_PORTS-1:0] = warn_en_q;
      reg_rdata[NUM_PORTS]     = frame_en_q;
      reg_rdata[NUM_PORTS+1]   = single_q;
    end
  end
endmodule

// File: rtl/fifo_realign_ctrl_chk.sv
module fifo_realign_ctrl_chk #(
  parameter int NUM_PORTS = 2,
  parameter int OW        = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    evt_clr,
  input logic [NUM_PORTS-1:0]    cmd,
  input logic [NUM_PORTS*OW-1:0] offset,
  input logic [NUM_PORTS-1:0]    busy,
  input logic [NUM_PORTS-1:0]    finish_evt,
  input logic                    aligned_event,
  input logic                    irq
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
    assert_cmd_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd[p] |=> !cmd[p]);
    assert_ack_with_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[p]) |-> cmd[p]);
    assert_offset_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[p] && $past(busy[p])) |-> $stable(offset[p*OW +: OW]));
  end

  assert_event_after_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned_event) |-> $past(|finish_evt));
  assert_event_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned_event && !evt_clr) |=> aligned_event);
  assert_irq_on_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    aligned_event |-> irq);
endmodule

bind fifo_realign_ctrl fifo_realign_ctrl_chk #(.NUM_PORTS(NUM_PORTS), .OW(OW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .evt_clr       (evt_clr_w),
  .cmd           (realign_cmd),
  .offset        (realign_offset),
  .busy          (busy_w),
  .finish_evt    (finish_evt_w),
  .aligned_event (aligned_event),
  .irq           (irq)
);

// File: tb/fifo_realign_ctrl_tb.sv
`timescale 1ns/1ps
module fifo_realign_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] frame_in = '0;
  logic [1:0] fifo_warn = '0;
  logic [1:0] fifo_realigned = '0;
  logic [1:0] realign_cmd;
  logic [5:0] realign_offset;
  logic       aligned_event;
  logic       irq;

  int checks = 0;
  int failures = 0;
  int cmd_cnt0 = 0;
  int cmd_cnt1 = 0;

  always #4 clk = ~clk;

  fifo_realign_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_in(frame_in),
    .fifo_warn(fifo_warn), .fifo_realigned(fifo_realigned),
    .realign_cmd(realign_cmd), .realign_offset(realign_offset),
    .aligned_event(aligned_event), .irq(irq)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      cmd_cnt0 += int'(realign_cmd[0]);
      cmd_cnt1 += int'(realign_cmd[1]);
    end
  end

  // {addr[17:16], wdata[15:8], expected readback[7:0]}
  localparam logic [17:0] VEC [7] = '{
    {2'd0, 8'hF5, 8'h05}, {2'd1, 8'h62, 8'h02}, {2'd0, 8'hF0, 8'h00},
    {2'd1, 8'h00, 8'h00}, {2'd3, 8'hFF, 8'h0F}, {2'd3, 8'h00, 8'h00},
    {2'd2, 8'hFE, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic done_pulse(input logic [1:0] m);
    @(negedge clk);
    fifo_realigned = m;
    @(negedge clk);
    fifo_realigned = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(5);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reg reset", v, 0);
    end
    chk("R1 cmd reset", realign_cmd, 0);
    chk("R1 event reset", aligned_event, 0);
    chk("R1 irq reset", irq, 0);

    // R2 / R9 register table
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][17:16], VEC[i][15:8]);
      rd(VEC[i][17:16], v);
      chk("R2/R9 table readback", v, VEC[i][7:0]);
    end
    idle(2);
    chk("R2 no cmd from field writes", cmd_cnt0 + cmd_cnt1, 0);

    // R3 software request on port A, offset 3
    wr(2'd0, 8'h0B);
    chk("R3 cmd not yet", realign_cmd[0], 0);
    @(negedge clk);
    chk("R3 cmd issued", realign_cmd[0], 1);
    chk("R12 offset A", realign_offset[2:0], 3);
    rd(2'd0, v); chk("R4 ack set", v, 8'h1B);
    @(negedge clk);
    chk("R3 cmd one cycle", realign_cmd[0], 0);
    // R5 offset change during handshake
    wr(2'd0, 8'h0E);
    rd(2'd0, v); chk("R5 reg offset updates", v, 8'h1E);
    chk("R5 captured offset", realign_offset[2:0], 3);
    wr(2'd0, 8'h06);
    rd(2'd0, v); chk("R4 ack held after release", v, 8'h16);
    done_pulse(2'b01);
    rd(2'd0, v); chk("R4 ack cleared", v, 8'h06);
    chk("R6 event set", aligned_event, 1);
    chk("R9 irq from event", irq, 1);
    rd(2'd2, v); chk("R6 event reg", v, 8'h01);
    chk("R8 one cmd A", cmd_cnt0, 1);

    // R7 clear semantics, R6 stray completion
    wr(2'd2, 8'h00);
    chk("R7 write 0 keeps", aligned_event, 1);
    wr(2'd2, 8'h01);
    chk("R7 write 1 clears", aligned_event, 0);
    chk("R9 irq drops", irq, 0);
    done_pulse(2'b10);
    chk("R6 stray ignored", aligned_event, 0);
    rd(2'd1, v); chk("R6 stray no ack", v, 8'h00);
    chk("R6 stray no cmd", cmd_cnt1, 0);

    // R8 queued request on port B
    wr(2'd1, 8'h09);
    @(negedge clk);
    chk("R3 cmd B", realign_cmd[1], 1);
    chk("R12 offset B", realign_offset[5:3], 1);
    wr(2'd1, 8'h01);
    wr(2'd1, 8'h0C);
    idle(3);
    chk("R8 held while pending", cmd_cnt1, 1);
    chk("R8 offset unchanged", realign_offset[5:3], 1);
    rd(2'd1, v); chk("R8 ack still set", v, 8'h1C);
    done_pulse(2'b10);
    rd(2'd1, v); chk("R4 ack drops at completion", v, 8'h0C);
    @(negedge clk);
    chk("R8 queued issued", realign_cmd[1], 1);
    chk("R8 queued offset", realign_offset[5:3], 4);
    rd(2'd1, v); chk("R8 ack again", v, 8'h1C);
    wr(2'd1, 8'h0C);
    // R7 completion beats clear in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h01; fifo_realigned = 2'b10;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; fifo_realigned = '0;
    chk("R7 set wins over clear", aligned_event, 1);
    rd(2'd1, v); chk("R4 ack B cleared", v, 8'h0C);
    wr(2'd1, 8'h04);
    idle(3);
    chk("R8 exactly two cmds B", cmd_cnt1, 2);
    wr(2'd2, 8'h01);

    // R9 warning interrupt gating
    wr(2'd3, 8'h01);
    fifo_warn = 2'b01; #1;
    chk("R9 warn A enabled", irq, 1);
    rd(2'd0, v); chk("R2 warn bit A", v, 8'h86);
    fifo_warn = 2'b10; #1;
    chk("R9 warn B disabled", irq, 0);
    rd(2'd1, v); chk("R2 warn bit B", v, 8'h84);
    wr(2'd3, 8'h02); #1;
    chk("R9 warn B enabled", irq, 1);
    fifo_warn = 2'b00; #1;
    chk("R9 no warn", irq, 0);
    wr(2'd3, 8'h00);

    // R10 frame trigger
    wr(2'd3, 8'h04);
    @(negedge clk); frame_in = 2'b01;
    @(negedge clk);
    chk("R10 frame cmd not yet", realign_cmd[0], 0);
    @(negedge clk);
    chk("R10 frame cmd", realign_cmd[0], 1);
    chk("R10 frame offset", realign_offset[2:0], 6);
    idle(3);
    frame_in = 2'b00;
    done_pulse(2'b01);
    idle(2);
    chk("R10 held frame one cmd", cmd_cnt0, 2);
    wr(2'd3, 8'h00);
    @(negedge clk); frame_in = 2'b01;
    idle(4);
    frame_in = 2'b00;
    idle(2);
    chk("R10 frame disabled", cmd_cnt0, 2);

    // R11 single-clock fan-out
    wr(2'd3, 8'h0C);
    @(negedge clk); frame_in = 2'b10;
    idle(4);
    frame_in = 2'b00;
    idle(2);
    chk("R11 frame B ignored", cmd_cnt0 + cmd_cnt1, 4);
    @(negedge clk); frame_in = 2'b01;
    @(negedge clk);
    @(negedge clk);
    chk("R11 both cmds", realign_cmd, 2'b11);
    chk("R12 both offsets", realign_offset, 6'b100_110);
    frame_in = 2'b00;
    done_pulse(2'b11);
    rd(2'd0, v); chk("R11 ack A cleared", v, 8'h06);
    rd(2'd1, v); chk("R11 ack B cleared", v, 8'h04);
    idle(2);
    chk("R11 cmd count A", cmd_cnt0, 3);
    chk("R11 cmd count B", cmd_cnt1, 3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule